// File: doc/BRIEF.md
# Register-Exchange Add-Compare-Select Core for a 64-State Rate-1/2 Code

This block is the recursion engine of a hard- or soft-decision Viterbi decoder for the rate-1/2, constraint-length-7 convolutional code with generators 171 and 133 (octal). It keeps one accumulated path metric and one 31-bit survivor register for each of the 64 trellis states. An upstream unit computes the four branch metrics, one for each possible code pair, and supplies erasures for punctured positions. Each cycle in which `in_valid` is high, the core runs one full add-compare-select step over all states. The step is built as 32 butterflies, each with two wings.

Survivors are kept by register exchange. Every destination state copies the survivor register of the predecessor it selects, shifts that register by one place, and appends the input bit that its own index implies. A six-level comparator tree finds the state with the smallest metric. The oldest bit of that state's survivor is the decoded output. Metrics are unsigned and are renormalised when the minimum grows past half the metric range.

Top module: `vit_acs_core`

## Requirements
- R1: A synchronous reset gives state 0 a metric of zero, gives every other state a metric of 2^(MW-2), and clears all survivors and the fill counter. On the cycle after reset, `best_state`=0, `best_metric`=0 and `out_valid`=0.
- R2: Trellis convention: from state s with input u, the next state is {u, s[5:1]}. The code pair is x = parity({u,s} & 7'o171) and y = parity({u,s} & 7'o133). The branch metric of code value c={x,y} sits at `bm_in[c*BMW +: BMW]`. For an error-free stream with zero metric on the sent pair, `best_state` equals the encoder state and `best_metric` stays 0.
- R3: Each state keeps the smaller of its two candidates, from predecessors 2s mod 64 and 2s+1 mod 64. On a tie it keeps the even predecessor. Without renormalisation, the minimum metric after a valid pair lies between the previous minimum and the previous minimum plus the largest branch metric.
- R4: `out_bit` is the bit in position SURV-1 of the survivor of the minimum-metric state. Once n ≥ 31 pairs have been accepted, it equals the input bit of pair n-31 on that path.
- R5: `out_valid` is 0 until 31 valid pairs have been accepted since reset. It rises after the 31st pair and stays high until the next reset.
- R6: A cycle with `in_valid` low changes no metric, no survivor and no output, whatever `bm_in` carries.
- R7: If the registered minimum metric is above 2^(MW-1), that minimum is subtracted from every metric before the branch metrics are added. No metric wraps around.
- R8: `best_state` and `best_metric` give the index and value of the smallest metric. Among equal metrics, the lowest index wins.
- R9: Single code-bit errors spaced at least 50 pairs apart are corrected. Under a metric of 7 per differing bit, `best_metric` equals 7 times the number of errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Branch metrics for one symbol pair are present |
| bm_in | input | 4*BMW | Four branch metrics, slice c is for code pair c={x,y} |
| out_valid | output | 1 | Survivors are full and `out_bit` is meaningful |
| out_bit | output | 1 | Decoded bit, 31 pairs behind the newest input |
| best_state | output | 6 | Index of the minimum-metric state |
| best_metric | output | MW | Value of the minimum metric |

## Verification
The bench runs an all-zero and an all-one stream to pin the state numbering and survivor direction. A swapped shift direction or a wrong predecessor pair shows up as a wrong `best_state` or a wrong decoded bit. A stream with every metric raised by a constant offset drives the minimum past the renormalisation point: a missing or misplaced subtraction wraps the metric or leaves it too high. A tie after a known first input checks that the comparator tree resolves to the lowest index rather than to a later one. Idle cycles carrying random metrics, and a fill count that must turn valid on exactly the 31st pair, catch a core that accepts data without `in_valid` or that has an off-by-one in its counter.

// File: rtl/vit_pkg.sv
package vit_pkg;
    localparam int unsigned CONSTR = 7;
    localparam int unsigned MEM    = CONSTR - 1;
    localparam int unsigned NST    = 1 << MEM;
    localparam logic [CONSTR-1:0] GEN_X = 7'o171;
    localparam logic [CONSTR-1:0] GEN_Y = 7'o133;

    // code pair {x,y} produced by input u leaving state prev
    function automatic logic [1:0] branch_code(input int unsigned u, input int unsigned prev);
        logic [CONSTR-1:0] r;
        r = CONSTR'((u << MEM) | prev);
        return {^(r & GEN_X), ^(r & GEN_Y)};
    endfunction
endpackage

// File: rtl/vit_bfly.sv
module vit_bfly
    import vit_pkg::*;
#(
    parameter int unsigned MW   = 10,
    parameter int unsigned BMW  = 4,
    parameter int unsigned SURV = 31,
    parameter int unsigned IDX  = 0
) (
    input  logic [MW-1:0]    pm_even_i,
    input  logic [MW-1:0]    pm_odd_i,
    input  logic [SURV-1:0]  sv_even_i,
    input  logic [SURV-1:0]  sv_odd_i,
    input  logic [4*BMW-1:0] bm_i,
    output logic [MW-1:0]    pm_lo_o,
    output logic [MW-1:0]    pm_hi_o,
    output logic [SURV-1:0]  sv_lo_o,
    output logic [SURV-1:0]  sv_hi_o
);
    // wing w serves destination IDX + w*NST/2, whose input bit is w
    for (genvar w = 0; w < 2; w++) begin : g_wing
        localparam int unsigned C_E = int'(branch_code(w, 2 * IDX));
        localparam int unsigned C_O = int'(branch_code(w, 2 * IDX + 1));
        logic [MW:0]     cand_e;
        logic [MW:0]     cand_o;
        logic            pick_odd;
        logic [MW-1:0]   pm_n;
        logic [SURV-1:0] sv_n;
        always_comb begin
            cand_e   = {1'b0, pm_even_i} + {{(MW + 1 - BMW){1'b0}}, bm_i[C_E*BMW +: BMW]};
            cand_o   = {1'b0, pm_odd_i}  + {{(MW + 1 - BMW){1'b0}}, bm_i[C_O*BMW +: BMW]};
            pick_odd = cand_o < cand_e;
            pm_n     = pick_odd ? cand_o[MW-1:0] : cand_e[MW-1:0];
            sv_n     = {pick_odd ? sv_odd_i[SURV-2:0] : sv_even_i[SURV-2:0], 1'(w)};
        end
    end

    assign pm_lo_o = g_wing[0].pm_n;
    assign pm_hi_o = g_wing[1].pm_n;
    assign sv_lo_o = g_wing[0].sv_n;
    assign sv_hi_o = g_wing[1].sv_n;
endmodule

// File: rtl/vit_minfind.sv
module vit_minfind #(
    parameter int unsigned N  = 64,
    parameter int unsigned MW = 10,
    localparam int unsigned LV = $clog2(N),
    localparam int unsigned IW = (LV > 0) ? LV : 1
) (
    input  logic [N-1:0][MW-1:0] metric_i,
    output logic [IW-1:0]        idx_o,
    output logic [MW-1:0]        val_o
);
    logic [MW-1:0] tv [LV+1][N];
    logic [IW-1:0] ti [LV+1][N];

    always_comb begin
        for (int l = 0; l <= LV; l++) begin
            for (int k = 0; k < N; k++) begin
                tv[l][k] = '0;
                ti[l][k] = '0;
            end
        end
        for (int k = 0; k < N; k++) begin
            tv[0][k] = metric_i[k];
            ti[0][k] = IW'(k);
        end
        // lower half of each pair holds lower indices: ties stay left
        for (int l = 0; l < LV; l++) begin
            for (int k = 0; k < (N >> (l + 1)); k++) begin
                if (tv[l][2*k+1] < tv[l][2*k]) begin
                    tv[l+1][k] = tv[l][2*k+1];
                    ti[l+1][k] = ti[l][2*k+1];
                end else begin
                    tv[l+1][k] = tv[l][2*k];
                    ti[l+1][k] = ti[l][2*k];
                end
            end
        end
    end

    assign idx_o = ti[LV][0];
    assign val_o = tv[LV][0];
endmodule

// File: rtl/vit_acs_core.sv
module vit_acs_core
    import vit_pkg::*;
#(
    parameter int unsigned MW   = 10,
    parameter int unsigned BMW  = 4,
    parameter int unsigned SURV = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [4*BMW-1:0] bm_in,
    output logic             out_valid,
    output logic             out_bit,
    output logic [MEM-1:0]   best_state,
    output logic [MW-1:0]    best_metric
);
    localparam int unsigned HALF_N   = NST / 2;
    localparam int unsigned CW       = $clog2(SURV + 1);
    localparam logic [MW-1:0] NORM_LIM = MW'(2 ** (MW - 1));
    localparam logic [MW-1:0] INIT_PM  = MW'(2 ** (MW - 2));

    typedef struct packed {
        logic [NST-1:0][MW-1:0]   pm;
        logic [NST-1:0][SURV-1:0] sv;
        logic [CW-1:0]            cnt;
        logic                     full;
    } acs_st_t;

    acs_st_t st_d, st_q;

    logic [MEM-1:0]  min_idx;
    logic [MW-1:0]   min_val;
    logic [MW-1:0]   sub_amt;
    logic [MW-1:0]   pm_adj [NST];
    logic [MW-1:0]   pm_nx  [NST];
    logic [SURV-1:0] sv_nx  [NST];

    vit_minfind #(.N(NST), .MW(MW)) u_min (
        .metric_i (st_q.pm),
        .idx_o    (min_idx),
        .val_o    (min_val)
    );

    always_comb begin
        sub_amt = (min_val > NORM_LIM) ? min_val : '0;
        for (int s = 0; s < NST; s++) begin
            pm_adj[s] = st_q.pm[s] - sub_amt;
        end
    end

    for (genvar j = 0; j < HALF_N; j++) begin : g_bf
        vit_bfly #(.MW(MW), .BMW(BMW), .SURV(SURV), .IDX(j)) u_bf (
            .pm_even_i (pm_adj[2*j]),
            .pm_odd_i  (pm_adj[2*j+1]),
            .sv_even_i (st_q.sv[2*j]),
            .sv_odd_i  (st_q.sv[2*j+1]),
            .bm_i      (bm_in),
            .pm_lo_o   (pm_nx[j]),
            .pm_hi_o   (pm_nx[j+HALF_N]),
            .sv_lo_o   (sv_nx[j]),
            .sv_hi_o   (sv_nx[j+HALF_N])
        );
    end

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            for (int s = 0; s < NST; s++) begin
                st_d.pm[s] = pm_nx[s];
                st_d.sv[s] = sv_nx[s];
            end
            if (!st_q.full) begin
                st_d.cnt  = st_q.cnt + 1'b1;
                st_d.full = (st_q.cnt + 1'b1) == CW'(SURV);
            end
        end
        if (rst) begin
            for (int s = 0; s < NST; s++) begin
                st_d.pm[s] = (s == 0) ? '0 : INIT_PM;
                st_d.sv[s] = '0;
            end
            st_d.cnt  = '0;
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign best_state  = min_idx;
    assign best_metric = min_val;
    assign out_bit     = st_q.sv[min_idx][SURV-1];
    assign out_valid   = st_q.full;
endmodule

module vit_acs_chk #(
    parameter int unsigned MW   = 10,
    parameter int unsigned BMW  = 4,
    parameter int unsigned SURV = 31
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          out_valid,
    input logic          out_bit,
    input logic [5:0]    best_state,
    input logic [MW-1:0] best_metric
);
    localparam int BM_MAX = 2 ** BMW - 1;
    localparam int LIM    = 2 ** (MW - 1);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (best_metric == '0 && best_state == '0 && !out_valid)); // R1

    AST_METRIC_STEP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && int'(best_metric) <= LIM) |=>
        (int'(best_metric) >= int'($past(best_metric)) &&
         int'(best_metric) <= int'($past(best_metric)) + BM_MAX)); // R3

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(best_metric) && $stable(best_state) &&
                       $stable(out_bit) && $stable(out_valid))); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(best_metric) <= LIM + BM_MAX); // R7
endmodule

bind vit_acs_core vit_acs_chk #(.MW(MW), .BMW(BMW), .SURV(SURV)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_bit     (out_bit),
    .best_state  (best_state),
    .best_metric (best_metric)
);

// File: tb/vit_acs_core_tb.sv
`timescale 1ns/1ps
module vit_acs_core_tb;
    localparam int MW   = 10;
    localparam int BMW  = 4;
    localparam int SURV = 31;
    localparam int LIM  = 2 ** (MW - 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [4*BMW-1:0] bm_in = '0;
    logic             out_valid;
    logic             out_bit;
    logic [5:0]       best_state;
    logic [MW-1:0]    best_metric;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 0;
    int   n;
    logic [5:0] enc;
    bit   hist [0:1023];

    always #2 clk = ~clk;

    vit_acs_core #(.MW(MW), .BMW(BMW), .SURV(SURV)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .bm_in(bm_in),
        .out_valid(out_valid), .out_bit(out_bit),
        .best_state(best_state), .best_metric(best_metric)
    );

    function automatic logic [1:0] enc_bits(input logic u, input logic [5:0] st);
        logic [6:0] r;
        r = {u, st};
        return {^(r & 7'o171), ^(r & 7'o133)};
    endfunction

    function automatic logic [4*BMW-1:0] mk_bm(input logic [1:0] rx, input int scale, input int offs);
        logic [4*BMW-1:0] v;
        v = '0;
        for (int c = 0; c < 4; c++) begin
            logic [1:0] cc;
            int d;
            cc = 2'(c);
            d  = int'(cc[1] ^ rx[1]) + int'(cc[0] ^ rx[0]);
            v[c*BMW +: BMW] = BMW'(d * scale + offs);
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        n = 0; enc = '0;
        chk(best_metric == '0, "R1 metric", int'(best_metric), 0);
        chk(best_state == '0, "R1 state", int'(best_state), 0);
        chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    endtask

    task automatic push(input logic u, input logic [1:0] flip, input int scale, input int offs);
        in_valid = 1'b1;
        bm_in    = mk_bm(enc_bits(u, enc) ^ flip, scale, offs);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        enc = {u, enc[5:1]};
        hist[n] = u;
        n++;
    endtask

    task automatic post_check(input int exp_m, input bit chk_state, input string mtag, input string dtag);
        chk(out_valid == (n >= SURV), "R5 out_valid", int'(out_valid), int'(n >= SURV));
        if (n >= SURV)
            chk(out_bit == hist[n-SURV], dtag, int'(out_bit), int'(hist[n-SURV]));
        chk(int'(best_metric) == exp_m, mtag, int'(best_metric), exp_m);
        if (chk_state)
            chk(best_state == enc, "R2 state", int'(best_state), int'(enc));
    endtask

    task automatic idle_check(input int cycles);
        logic [MW-1:0] m0; logic [5:0] s0; logic b0, v0;
        m0 = best_metric; s0 = best_state; b0 = out_bit; v0 = out_valid;
        for (int i = 0; i < cycles; i++) begin
            in_valid = 1'b0;
            bm_in    = 16'($urandom);
            @(posedge clk); @(negedge clk);
        end
        chk(best_metric == m0 && best_state == s0 && out_bit == b0 && out_valid == v0,
            "R6 idle", int'(best_metric), int'(m0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int errs, last_err, m;
        bit norm_seen;
        void'($urandom(32'd4242));

        // R1 reset, then R2/R4/R5 with an all-zero stream
        do_reset();
        for (int i = 0; i < 40; i++) begin
            push(1'b0, 2'b00, 7, 0);
            post_check(0, 1, "R2 metric", "R4 zero");
        end

        // all-one stream: encoder ends in state 63
        do_reset();
        for (int i = 0; i < 40; i++) begin
            push(1'b1, 2'b00, 7, 0);
            post_check(0, 1, "R2 metric", "R4 ones");
        end

        // random data, sparse single-bit errors, idle gaps (R9, R6, R3)
        do_reset();
        errs = 0; last_err = -100;
        for (int i = 0; i < 320; i++) begin
            logic [1:0] fl;
            fl = 2'b00;
            if (i % 50 == 20) begin
                fl = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
                errs++; last_err = i;
            end
            push(1'($urandom), fl, 7, 0);
            post_check(errs * 7, (i - last_err) >= 12, "R9 metric", "R9 decode");
            if ($urandom % 8 == 0) idle_check(1 + int'($urandom % 3));
        end

        // constant offset on all metrics drives renormalisation (R7)
        do_reset();
        m = 0; norm_seen = 0;
        for (int i = 0; i < 150; i++) begin
            if (m > LIM) begin m = 0; norm_seen = 1; end
            m = m + 8;
            push(1'($urandom), 2'b00, 3, 8);
            post_check(m, 1, "R7 metric", "R7 decode");
        end
        chk(norm_seen, "R7 renormalised", int'(norm_seen), 1);

        // tie: after u=1 from state 0, flat zero metrics leave 16 and 48 at zero (R8)
        do_reset();
        push(1'b1, 2'b00, 7, 0);
        in_valid = 1'b1; bm_in = '0;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        chk(best_state == 6'd16, "R8 tie index", int'(best_state), 16);
        chk(best_metric == '0, "R8 tie metric", int'(best_metric), 0);

        // mid-run reset returns to the reset state (R1)
        for (int i = 0; i < 35; i++) push(1'($urandom), 2'b00, 7, 0);
        chk(out_valid == 1'b1, "R5 filled", int'(out_valid), 1);
        do_reset();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule